// File: doc/BRIEF.md
# Host-Port Byte Streaming Engine

This block carries words written by a local processor out to an external host, one byte at a time, under a request/acknowledge handshake. The processor writes a word into a single holding register. An empty flag and a service request tell the processor when the next word may be written. When the streaming path is enabled, the block copies the held word into a set of receive byte registers on its own. It then walks an internal byte-address counter across those bytes and raises a request to the host for each one. On each acknowledge it drives the selected byte onto the host bus.

A 2-bit mode value decides which byte a word starts at. Every copy reloads the counter from this value. The block keeps presenting bytes until it has sent the byte at the highest address, and only then does it take the next word. The host acknowledge arrives from another clock domain and passes through a two-flop synchroniser. A synchronous active-high reset returns the engine to idle.

Top module: `hostdma_stream`

## Requirements
- R1: After reset, tx_empty is 1, host_req is 0, host_oe is 0 and host_data is 0. svc_req is 0 while irq_en and dma_en are both 0.
- R2: svc_req is 1 exactly when tx_empty is 1 and at least one of irq_en or dma_en is 1.
- R3: A cycle with tx_wr high and tx_empty 1 stores tx_word and clears tx_empty. A tx_wr while tx_empty is 0 is ignored, and the held word is left unchanged.
- R4: The held word is copied into the receive bytes only when all of the following hold: stream_mode is not 00, xfer_en is 1, the receive bytes are empty and tx_empty is 0. Each copy sets tx_empty back to 1. With stream_mode 00 or xfer_en 0, no word is copied and host_req stays 0.
- R5: Each copy reloads the byte address from stream_mode. Address 0 is bits 15:8 of the word and address 1 (the highest) is bits 7:0. Mode 01 or 11 starts at address 0, and mode 10 starts at address 1.
- R6: host_req is 1 while a byte is waiting for the host. It falls no later than 4 cycles after host_ack rises, and it never rises before host_ack is seen low.
- R7: host_oe is 1 only while the synchronised acknowledge is high during a byte transfer. While host_oe is 1, host_data carries the selected byte. Otherwise host_oe is 0 and host_data is 0.
- R8: After host_ack falls on a byte below the highest address, the address advances by one and host_req rises again for the next byte.
- R9: After host_ack falls on the byte at the highest address, the receive bytes become empty. A word that is already held is then copied next, and with no word held, host_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_wr | input | 1 | Processor write strobe for the holding register |
| tx_word | input | 16 | Word written by the processor |
| irq_en | input | 1 | Interrupt-driven service enable |
| dma_en | input | 1 | On-chip DMA service enable |
| stream_mode | input | 2 | Start-byte mode; 00 disables streaming |
| xfer_en | input | 1 | Transmit-request enable for streaming |
| tx_empty | output | 1 | Holding register is free |
| svc_req | output | 1 | Processor-side service request |
| host_ack | input | 1 | Host acknowledge, asynchronous |
| host_req | output | 1 | Request to the host for the next byte |
| host_oe | output | 1 | Host data bus drive enable |
| host_data | output | 8 | Byte presented to the host |

## Verification
A counter that reloads wrongly, or one that advances at the wrong point, shows up within a single word as a byte order that is wrong or as a byte count that is wrong. The bench sees this at the first host_oe window or the second. A receive-full flag that is stuck or cleared too early shows up in two ways: a second word is lost or arrives early, or host_req rises with nothing queued. The bench checks the value of every byte and requires host_req to stay low once the queue has drained. A fault in the empty flag shows up on svc_req and tx_empty in the cycle after a write or a copy.

// File: rtl/hostdma_pkg.sv
package hostdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SEND = 2'd2
    } seq_state_t;

    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_LOWST = 2'b10;
endpackage

// File: rtl/hostdma_sync.sv
module hostdma_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hostdma_holding.sv
module hostdma_holding #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              take,
    output logic [WORD_W-1:0] word,
    output logic              empty
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              empty;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take) begin
            h_d.empty = 1'b1;
        end else if (wr && h_q.empty) begin
            h_d.word  = wr_word;
            h_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q.word  <= '0;
            h_q.empty <= 1'b1;
        end else begin
            h_q <= h_d;
        end
    end

    assign word  = h_q.word;
    assign empty = h_q.empty;

    assert_write_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && empty && !take) |=> (!empty && word == $past(wr_word)));
    assert_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (!empty && !take) |=> (!empty && $stable(word)));
    assert_take_only_full_R4: assert property (@(posedge clk) disable iff (rst)
        take |-> !empty);
endmodule

// File: rtl/hostdma_seq.sv
module hostdma_seq
    import hostdma_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stream_on,
    input  logic [1:0]        mode,
    input  logic              hold_empty,
    input  logic [WORD_W-1:0] hold_word,
    input  logic              ack_s,
    output logic              take,
    output logic              req,
    output logic              oe,
    output logic [BYTE_W-1:0] data
);
    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int ADDR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NBYTES - 1);

    typedef struct packed {
        seq_state_t        state;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] rx;
        logic              rx_full;
    } seq_t;

    seq_t s_d, s_q;
    logic [ADDR_W-1:0] start_addr;
    logic [BYTE_W-1:0] sel_byte;

    always_comb begin
        start_addr = (mode == MODE_LOWST) ? LAST_ADDR : '0;
    end

    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (s_q.addr == ADDR_W'(i))
                sel_byte = s_q.rx[(NBYTES-1-i)*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (stream_on && !hold_empty && !s_q.rx_full && !ack_s) begin
                    take      = 1'b1;
                    s_d.rx      = hold_word;
                    s_d.rx_full = 1'b1;
                    s_d.addr    = start_addr;
                    s_d.state   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (ack_s) s_d.state = ST_SEND;
            end
            ST_SEND: begin
                if (!ack_s) begin
                    if (s_q.addr == LAST_ADDR) begin
                        s_d.rx_full = 1'b0;
                        s_d.state   = ST_IDLE;
                    end else begin
                        s_d.addr  = s_q.addr + ADDR_W'(1);
                        s_d.state = ST_REQ;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.state   <= ST_IDLE;
            s_q.addr    <= '0;
            s_q.rx      <= '0;
            s_q.rx_full <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req  = (s_q.state == ST_REQ);
    assign oe   = (s_q.state == ST_SEND) && ack_s;
    assign data = oe ? sel_byte : '0;

    assert_start_addr_R5: assert property (@(posedge clk) disable iff (rst)
        take |=> (s_q.addr == ((($past(mode)) == MODE_LOWST) ? LAST_ADDR : '0)));
    assert_req_needs_data_R6: assert property (@(posedge clk) disable iff (rst)
        req |-> s_q.rx_full);
    assert_req_oe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(req && oe));
    assert_advance_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(req) && !$past(take)) |-> (s_q.addr == $past(s_q.addr) + ADDR_W'(1)));
    assert_drain_last_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(s_q.rx_full) |-> ($past(s_q.addr) == LAST_ADDR));
endmodule

// File: rtl/hostdma_stream.sv
module hostdma_stream
    import hostdma_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              irq_en,
    input  logic              dma_en,
    input  logic [1:0]        stream_mode,
    input  logic              xfer_en,
    output logic              tx_empty,
    output logic              svc_req,
    input  logic              host_ack,
    output logic              host_req,
    output logic              host_oe,
    output logic [BYTE_W-1:0] host_data
);
    logic              ack_s;
    logic              take;
    logic [WORD_W-1:0] hold_word;
    logic              stream_on;

    assign stream_on = (stream_mode != MODE_OFF) && xfer_en;

    hostdma_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (host_ack),
        .sync_out (ack_s)
    );

    hostdma_holding #(.WORD_W(WORD_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr      (tx_wr),
        .wr_word (tx_word),
        .take    (take),
        .word    (hold_word),
        .empty   (tx_empty)
    );

    hostdma_seq #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .stream_on  (stream_on),
        .mode       (stream_mode),
        .hold_empty (tx_empty),
        .hold_word  (hold_word),
        .ack_s      (ack_s),
        .take       (take),
        .req        (host_req),
        .oe         (host_oe),
        .data       (host_data)
    );

    assign svc_req = tx_empty && (irq_en || dma_en);

    assert_copy_gated_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(host_req) |-> $past(stream_on) || $past(host_oe) || $past(ack_s));
    assert_bus_released_R7: assert property (@(posedge clk) disable iff (rst)
        !host_oe |-> (host_data == '0));
endmodule

// File: tb/hostdma_stream_test.sv
module hostdma_stream_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        tx_wr;
    logic [15:0] tx_word;
    logic        irq_en, dma_en, xfer_en;
    logic [1:0]  stream_mode;
    logic        tx_empty, svc_req;
    logic        host_ack;
    logic        host_req, host_oe;
    logic [7:0]  host_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    hostdma_stream uut (
        .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_word(tx_word),
        .irq_en(irq_en), .dma_en(dma_en), .stream_mode(stream_mode),
        .xfer_en(xfer_en), .tx_empty(tx_empty), .svc_req(svc_req),
        .host_ack(host_ack), .host_req(host_req), .host_oe(host_oe),
        .host_data(host_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] w);
        @(negedge clk);
        tx_wr = 1'b1; tx_word = w;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic get_byte(input string tag, input logic [7:0] exp);
        int n;
        n = 0;
        while (!host_req && n < 20) begin @(negedge clk); n++; end
        check(host_req == 1'b1, {tag, " R6 req"}, host_req, 1);
        check(host_oe == 1'b0, {tag, " R7 oe idle"}, host_oe, 0);
        host_ack = 1'b1;
        n = 0;
        while (!host_oe && n < 10) begin @(negedge clk); n++; end
        check(n <= 4, {tag, " R6 ack latency"}, n, 4);
        check(host_req == 1'b0, {tag, " R6 req drop"}, host_req, 0);
        check(host_data == exp, {tag, " R7 data"}, host_data, exp);
        host_ack = 1'b0;
        n = 0;
        while (host_oe && n < 10) begin @(negedge clk); n++; end
        check(host_data == 8'h00, {tag, " R7 released"}, host_data, 0);
    endtask

    task automatic expect_quiet(input string tag);
        bit seen;
        seen = 1'b0;
        repeat (12) begin @(negedge clk); if (host_req) seen = 1'b1; end
        check(!seen, tag, seen, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
        check(host_req == 1'b0, "R1 host_req", host_req, 0);
        check(host_oe == 1'b0 && host_data == 8'h00, "R1 bus", host_data, 0);
        check(svc_req == 1'b0, "R1 svc_req", svc_req, 0);
    endtask

    task automatic t_svc;
        irq_en = 1'b1; @(negedge clk);
        check(svc_req == 1'b1, "R2 irq_en", svc_req, 1);
        irq_en = 1'b0; dma_en = 1'b1; @(negedge clk);
        check(svc_req == 1'b1, "R2 dma_en", svc_req, 1);
        dma_en = 1'b0; @(negedge clk);
        check(svc_req == 1'b0, "R2 none", svc_req, 0);
        dma_en = 1'b1;
    endtask

    task automatic t_gated;
        stream_mode = 2'b00; xfer_en = 1'b1;
        write_word(16'hC3D4);
        check(tx_empty == 1'b0, "R3 write clears empty", tx_empty, 0);
        check(svc_req == 1'b0, "R2 no req when full", svc_req, 1'b0);
        expect_quiet("R4 mode 00 holds");
        stream_mode = 2'b01; xfer_en = 1'b0;
        expect_quiet("R4 xfer_en 0 holds");
        check(tx_empty == 1'b0, "R4 still held", tx_empty, 0);
        xfer_en = 1'b1;
        repeat (2) @(negedge clk);
        check(tx_empty == 1'b1, "R4 copy sets empty", tx_empty, 1);
        get_byte("R5 mode01 hi", 8'hC3);
        get_byte("R8 next lo", 8'hD4);
        expect_quiet("R9 drained");
    endtask

    task automatic t_mode_low;
        stream_mode = 2'b10;
        write_word(16'h1234);
        get_byte("R5 mode10 lo", 8'h34);
        expect_quiet("R9 single byte then idle");
        stream_mode = 2'b11;
        write_word(16'h9A7E);
        get_byte("R5 mode11 hi", 8'h9A);
        get_byte("R8 mode11 lo", 8'h7E);
        expect_quiet("R9 mode11 drained");
    endtask

    task automatic t_queue;
        stream_mode = 2'b01;
        write_word(16'hA55A);
        repeat (2) @(negedge clk);
        write_word(16'hBEEF);
        check(tx_empty == 1'b0, "R3 second word held", tx_empty, 0);
        write_word(16'hDEAD);
        check(tx_empty == 1'b0, "R3 third write ignored", tx_empty, 0);
        get_byte("R8 w1 hi", 8'hA5);
        get_byte("R8 w1 lo", 8'h5A);
        get_byte("R9 w2 hi", 8'hBE);
        get_byte("R3 w2 lo kept", 8'hEF);
        check(tx_empty == 1'b1, "R4 empty after queue", tx_empty, 1);
        expect_quiet("R3 dropped word never sent");
    endtask

    initial begin
        rst = 1'b1; tx_wr = 1'b0; tx_word = '0; irq_en = 1'b0; dma_en = 1'b0;
        xfer_en = 1'b0; stream_mode = 2'b00; host_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_svc();
        t_gated();
        t_mode_low();
        t_queue();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule